// File: doc/BRIEF.md
# Privilege and Exception Sequencer

This block is the control heart of a small memory-to-memory processor that runs in one of two privilege levels. Each time the instruction pipeline hands it a completed instruction step, it decides where the program counter goes next. The normal case is the following instruction, four bytes on. The other case is a fixed handler address, taken when the step cannot be allowed to finish. It owns the program counter, a single saved-PC register and the privilege bit.

The reserved region is the set of addresses below a limit of 100. Protection against it applies only at the unprivileged level. Instruction fetches and operand addresses that fall inside the region are refused. The operand addresses include the second-level address of an indirect load. An unprivileged attempt to write the privilege bit is also refused. A trap instruction enters the privileged level on purpose. A periodic timer line forces entry regardless of what the program is doing. A return instruction goes back to unprivileged code by exchanging the program counter with the saved copy.

Each step arrives as one `step_i` pulse. The decode and execute stages supply the instruction's attributes with it. The registered outputs report the new program counter, the saved PC, the privilege bit and the cause of the decision. They also carry two strobes. One is a one-cycle redirect that tells the pipeline to flush. The other is a one-cycle retire that grants the instruction's architectural writes.

Top module: `priv_seq`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `pc_o` is 0, `epc_o` is 0, `mode_o` is 0 (privileged), and `redirect_o` and `retire_o` are low.
- R2: A step with no pending cause advances `pc_o` by 4, modulo 256. It leaves `epc_o` unchanged, pulses `retire_o` for one cycle, keeps `redirect_o` low and reports cause code 0.
- R3: In user mode (`mode_o`=1), a step whose `pc_o` is below 100 is refused. `pc_o` becomes 60 and the cause code is 2. A `pc_o` of 100 is allowed.
- R4: In user mode, a step is refused when any valid operand address is below 100. Every operand port is checked, including the indirect target port. `pc_o` becomes 60 and the cause code is 5. An operand port whose valid bit is low is never checked.
- R5: In user mode, a step with `dst_mode_i` set is refused. `pc_o` becomes 64 and the cause code is 4. The only way user mode reaches mode 0 is through such a vectored entry.
- R6: A step with `trap_i` set goes to 68 with cause code 3.
- R7: A step with `irq_i` high goes to 72 with cause code 1, in either mode. It is taken ahead of the fetch address check.
- R8: On every vectored entry (cause codes 1 to 5), `epc_o` receives the old `pc_o` and `mode_o` becomes 0. `redirect_o` pulses for one cycle and `retire_o` stays low, so the refused step has no side effects.
- R9: When several causes are pending in one step, one cause wins, in this order. Interrupt comes first, then fetch violation, trap, mode-write violation, operand violation, and return last.
- R10: A step with `rte_i` set and no higher cause exchanges `pc_o` and `epc_o` and sets `mode_o` to 1. It reports cause code 6 and pulses `redirect_o`, all in one cycle.
- R11: Without `step_i`, `pc_o`, `epc_o` and `mode_o` hold and both strobes stay low, whatever the other inputs are.
- R12: In mode 0 none of the address checks apply. A normal step with `dst_mode_i` set loads `mode_o` from `mode_wdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | One instruction step is presented this cycle |
| irq_i | input | 1 | Periodic timer interrupt line |
| trap_i | input | 1 | Decoded instruction is a trap |
| rte_i | input | 1 | Decoded instruction is a return from exception |
| dst_mode_i | input | 1 | Decoded instruction writes the privilege bit |
| mode_wdata_i | input | 1 | Value written to the privilege bit |
| opnd_vld_i | input | NOPND | Per operand port: address is used |
| opnd_addr_i | input | NOPND*AW | Packed operand addresses, port k at bits k*AW upward |
| pc_o | output | AW | Program counter (next fetch address) |
| epc_o | output | AW | Saved program counter |
| mode_o | output | 1 | Privilege bit, 0 privileged, 1 user |
| redirect_o | output | 1 | One-cycle flush/redirect strobe |
| retire_o | output | 1 | One-cycle commit grant for the last step |
| cause_o | output | 3 | Cause code of the last step |

## Verification
Some properties are checked on every cycle by the assertions:
- the reset state;
- the interrupt entry and the saving of the PC;
- the redirect for a user fetch below the limit;
- the privileged mode and suppressed retire on every vectored entry;
- the exchange performed by a return;
- the plus-four advance on retire;
- the hold when no step arrives.

The bench sweeps every combination of the five cause inputs. It runs them at program counters on both sides of the limit, in both modes, with the failing operand placed on each port in turn. That sweep is the only thing that shows the full priority order, the operand boundary at 99 and 100, and the wrap of the counter. It also shows that invalid operand ports are ignored and that a privileged mode write succeeds.

// File: rtl/priv_seq_pkg.sv
package priv_seq_pkg;
  typedef enum logic [2:0] {
    CS_NONE  = 3'd0,
    CS_IRQ   = 3'd1,
    CS_FETCH = 3'd2,
    CS_TRAP  = 3'd3,
    CS_MODE  = 3'd4,
    CS_OPND  = 3'd5,
    CS_RTE   = 3'd6
  } cause_e;

  function automatic logic is_vectored(cause_e c);
    return (c != CS_NONE) && (c != CS_RTE);
  endfunction
endpackage

// File: rtl/priv_seq_guard.sv
module priv_seq_guard #(
  parameter int AW    = 8,
  parameter int NOPND = 3,
  parameter int LIMIT = 100
) (
  input  logic              user_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [NOPND-1:0]  opnd_vld_i,
  input  logic [NOPND*AW-1:0] opnd_addr_i,
  output logic              fetch_bad_o,
  output logic              opnd_bad_o
);
  localparam logic [AW-1:0] LIM = AW'(LIMIT);

  logic [NOPND-1:0] low_hit;

  for (genvar g = 0; g < NOPND; g++) begin : g_port
    assign low_hit[g] = opnd_vld_i[g] && (opnd_addr_i[g*AW +: AW] < LIM);
  end

  assign fetch_bad_o = user_i && (pc_i < LIM);
  assign opnd_bad_o  = user_i && (|low_hit);
endmodule

// File: rtl/priv_seq_arb.sv
module priv_seq_arb
  import priv_seq_pkg::*;
#(
  parameter int AW       = 8,
  parameter int VEC_MEM  = 60,
  parameter int VEC_MODE = 64,
  parameter int VEC_TRAP = 68,
  parameter int VEC_IRQ  = 72
) (
  input  logic          irq_i,
  input  logic          fetch_bad_i,
  input  logic          trap_i,
  input  logic          mode_bad_i,
  input  logic          opnd_bad_i,
  input  logic          rte_i,
  output cause_e        cause_o,
  output logic [AW-1:0] vec_o
);
  localparam logic [AW-1:0] V_MEM  = AW'(VEC_MEM);
  localparam logic [AW-1:0] V_MODE = AW'(VEC_MODE);
  localparam logic [AW-1:0] V_TRAP = AW'(VEC_TRAP);
  localparam logic [AW-1:0] V_IRQ  = AW'(VEC_IRQ);

  always_comb begin
    if (irq_i)            cause_o = CS_IRQ;
    else if (fetch_bad_i) cause_o = CS_FETCH;
    else if (trap_i)      cause_o = CS_TRAP;
    else if (mode_bad_i)  cause_o = CS_MODE;
    else if (opnd_bad_i)  cause_o = CS_OPND;
    else if (rte_i)       cause_o = CS_RTE;
    else                  cause_o = CS_NONE;
  end

  always_comb begin
    unique case (cause_o)
      CS_IRQ:  vec_o = V_IRQ;
      CS_TRAP: vec_o = V_TRAP;
      CS_MODE: vec_o = V_MODE;
      default: vec_o = V_MEM;
    endcase
  end
endmodule

// File: rtl/priv_seq_state.sv
module priv_seq_state
  import priv_seq_pkg::*;
#(
  parameter int AW        = 8,
  parameter int INSTR_LEN = 4,
  parameter int RESET_PC  = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  cause_e        cause_i,
  input  logic [AW-1:0] vec_i,
  input  logic          mode_wr_i,
  input  logic          mode_wdata_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] epc_o,
  output logic          mode_o,
  output logic          redirect_o,
  output logic          retire_o,
  output cause_e        cause_o
);
  localparam logic [AW-1:0] ADV  = AW'(INSTR_LEN);
  localparam logic [AW-1:0] PC0  = AW'(RESET_PC);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o       <= PC0;
      epc_o      <= '0;
      mode_o     <= 1'b0;
      redirect_o <= 1'b0;
      retire_o   <= 1'b0;
      cause_o    <= CS_NONE;
    end else begin
      redirect_o <= 1'b0;
      retire_o   <= 1'b0;
      if (step_i) begin
        cause_o <= cause_i;
        if (cause_i == CS_NONE) begin
          pc_o     <= pc_o + ADV;
          retire_o <= 1'b1;
          if (mode_wr_i) mode_o <= mode_wdata_i;
        end else if (cause_i == CS_RTE) begin
          pc_o       <= epc_o;
          epc_o      <= pc_o;
          mode_o     <= 1'b1;
          redirect_o <= 1'b1;
        end else begin
          epc_o      <= pc_o;
          pc_o       <= vec_i;
          mode_o     <= 1'b0;
          redirect_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/priv_seq.sv
module priv_seq
  import priv_seq_pkg::*;
#(
  parameter int AW        = 8,
  parameter int NOPND     = 3,
  parameter int LIMIT     = 100,
  parameter int INSTR_LEN = 4,
  parameter int RESET_PC  = 0,
  parameter int VEC_MEM   = 60,
  parameter int VEC_MODE  = 64,
  parameter int VEC_TRAP  = 68,
  parameter int VEC_IRQ   = 72
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step_i,
  input  logic                irq_i,
  input  logic                trap_i,
  input  logic                rte_i,
  input  logic                dst_mode_i,
  input  logic                mode_wdata_i,
  input  logic [NOPND-1:0]    opnd_vld_i,
  input  logic [NOPND*AW-1:0] opnd_addr_i,
  output logic [AW-1:0]       pc_o,
  output logic [AW-1:0]       epc_o,
  output logic                mode_o,
  output logic                redirect_o,
  output logic                retire_o,
  output logic [2:0]          cause_o
);
  logic          fetch_bad, opnd_bad, mode_bad;
  cause_e        cause_now, cause_q;
  logic [AW-1:0] vec;

  priv_seq_guard #(.AW(AW), .NOPND(NOPND), .LIMIT(LIMIT)) guard_i (
    .user_i      (mode_o),
    .pc_i        (pc_o),
    .opnd_vld_i  (opnd_vld_i),
    .opnd_addr_i (opnd_addr_i),
    .fetch_bad_o (fetch_bad),
    .opnd_bad_o  (opnd_bad)
  );

  assign mode_bad = mode_o && dst_mode_i;

  priv_seq_arb #(
    .AW(AW), .VEC_MEM(VEC_MEM), .VEC_MODE(VEC_MODE),
    .VEC_TRAP(VEC_TRAP), .VEC_IRQ(VEC_IRQ)
  ) arb_i (
    .irq_i       (irq_i),
    .fetch_bad_i (fetch_bad),
    .trap_i      (trap_i),
    .mode_bad_i  (mode_bad),
    .opnd_bad_i  (opnd_bad),
    .rte_i       (rte_i),
    .cause_o     (cause_now),
    .vec_o       (vec)
  );

  priv_seq_state #(.AW(AW), .INSTR_LEN(INSTR_LEN), .RESET_PC(RESET_PC)) state_i (
    .clk          (clk),
    .rst          (rst),
    .step_i       (step_i),
    .cause_i      (cause_now),
    .vec_i        (vec),
    .mode_wr_i    (dst_mode_i && !mode_o),
    .mode_wdata_i (mode_wdata_i),
    .pc_o         (pc_o),
    .epc_o        (epc_o),
    .mode_o       (mode_o),
    .redirect_o   (redirect_o),
    .retire_o     (retire_o),
    .cause_o      (cause_q)
  );

  assign cause_o = cause_q;
endmodule

// File: rtl/priv_seq_chk.sv
module priv_seq_chk #(
  parameter int AW        = 8,
  parameter int LIMIT     = 100,
  parameter int INSTR_LEN = 4,
  parameter int RESET_PC  = 0,
  parameter int VEC_MEM   = 60,
  parameter int VEC_IRQ   = 72
) (
  input logic          clk,
  input logic          rst,
  input logic          step_i,
  input logic          irq_i,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] epc_o,
  input logic          mode_o,
  input logic          redirect_o,
  input logic          retire_o,
  input logic [2:0]    cause_o
);
  localparam logic [AW-1:0] LIM  = AW'(LIMIT);
  localparam logic [AW-1:0] ADV  = AW'(INSTR_LEN);
  localparam logic [AW-1:0] PC0  = AW'(RESET_PC);
  localparam logic [AW-1:0] VM   = AW'(VEC_MEM);
  localparam logic [AW-1:0] VI   = AW'(VEC_IRQ);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (pc_o == PC0 && epc_o == '0 && !mode_o && !redirect_o && !retire_o)); // R1

  AST_RETIRE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    retire_o |-> (pc_o == $past(pc_o) + ADV && !redirect_o)); // R2

  AST_FETCH_GUARD: assert property (@(posedge clk) disable iff (rst)
    (step_i && !irq_i && mode_o && pc_o < LIM) |=> (pc_o == VM && cause_o == 3'd2)); // R3

  AST_USER_NO_SELF_DROP: assert property (@(posedge clk) disable iff (rst)
    (step_i && mode_o) |=> (mode_o || redirect_o)); // R5

  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (step_i && irq_i) |=> (pc_o == VI && epc_o == $past(pc_o) && !mode_o && cause_o == 3'd1)); // R7

  AST_VECTOR_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (redirect_o && cause_o != 3'd6) |-> (!mode_o && !retire_o)); // R8

  AST_RTE_SWAP: assert property (@(posedge clk) disable iff (rst)
    (redirect_o && cause_o == 3'd6) |-> (mode_o && pc_o == $past(epc_o) && epc_o == $past(pc_o))); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> ($stable(pc_o) && $stable(epc_o) && $stable(mode_o) && !redirect_o && !retire_o)); // R11
endmodule

bind priv_seq priv_seq_chk #(
  .AW(AW), .LIMIT(LIMIT), .INSTR_LEN(INSTR_LEN), .RESET_PC(RESET_PC),
  .VEC_MEM(VEC_MEM), .VEC_IRQ(VEC_IRQ)
) chk_i (
  .clk(clk), .rst(rst), .step_i(step_i), .irq_i(irq_i),
  .pc_o(pc_o), .epc_o(epc_o), .mode_o(mode_o),
  .redirect_o(redirect_o), .retire_o(retire_o), .cause_o(cause_o)
);

// File: tb/priv_seq_tb_top.sv
module priv_seq_tb_top;
  localparam int AW = 8;
  localparam int NOPND = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, step_i, irq_i, trap_i, rte_i, dst_mode_i, mode_wdata_i;
  logic [NOPND-1:0]    opnd_vld_i;
  logic [NOPND*AW-1:0] opnd_addr_i;
  logic [AW-1:0] pc_o, epc_o;
  logic mode_o, redirect_o, retire_o;
  logic [2:0] cause_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  priv_seq dut_i (
    .clk(clk), .rst(rst), .step_i(step_i), .irq_i(irq_i), .trap_i(trap_i),
    .rte_i(rte_i), .dst_mode_i(dst_mode_i), .mode_wdata_i(mode_wdata_i),
    .opnd_vld_i(opnd_vld_i), .opnd_addr_i(opnd_addr_i),
    .pc_o(pc_o), .epc_o(epc_o), .mode_o(mode_o),
    .redirect_o(redirect_o), .retire_o(retire_o), .cause_o(cause_o)
  );

  function automatic int pack(int pc, int epc, int md, int cs, int rd, int rt);
    return ((pc & 255) << 14) | ((epc & 255) << 6) | ((md & 1) << 5) |
           ((cs & 7) << 2) | ((rd & 1) << 1) | (rt & 1);
  endfunction

  function automatic int observed();
    return pack(int'(pc_o), int'(epc_o), int'(mode_o), int'(cause_o),
                int'(redirect_o), int'(retire_o));
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (pc,epc,mode,cause,redir,retire packed)",
               tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    step_i = 0; irq_i = 0; trap_i = 0; rte_i = 0; dst_mode_i = 0;
    mode_wdata_i = 0; opnd_vld_i = '0; opnd_addr_i = '0;
  endtask

  task automatic do_reset();
    clear_in();
    rst = 1;
    tick();
    tick();
    rst = 0;
  endtask

  task automatic one_step();
    step_i = 1;
    tick();
    clear_in();
  endtask

  // Reach pc=target; in user mode epc ends at 72 (via irq then return).
  task automatic reach(int target, bit user);
    do_reset();
    for (int i = 0; i < target / 4; i++) one_step();
    if (user) begin
      irq_i = 1;
      one_step();
      rte_i = 1;
      one_step();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int pcs[6];
    pcs = '{0, 96, 100, 104, 200, 252};
    rst = 1;
    clear_in();
    @(negedge clk);
    do_reset();
    check("R1 reset state", observed(), pack(0, 0, 0, 0, 0, 0));

    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 6; p++) begin
        for (int c = 0; c < 32; c++) begin
          int pc, epc, ex_pc, ex_epc, ex_md, ex_cs, ex_rd, ex_rt, vec, npend, fport;
          bit irq, trp, dstm, flt, rte, fbad, obad, mbad;
          string tag;
          pc = pcs[p];
          reach(pc, m[0]);
          epc = m[0] ? 72 : 0;
          irq = c[0]; trp = c[1]; dstm = c[2]; flt = c[3]; rte = c[4];
          fport = (p + c) % NOPND;
          fbad = m[0] && (pc < 100);
          obad = m[0] && flt;
          mbad = m[0] && dstm;
          npend = int'(irq) + int'(fbad) + int'(trp) + int'(mbad) + int'(obad) + int'(rte);
          vec = 0;
          ex_cs = 0;
          if (irq)       begin ex_cs = 1; vec = 72; tag = "R7"; end
          else if (fbad) begin ex_cs = 2; vec = 60; tag = "R3"; end
          else if (trp)  begin ex_cs = 3; vec = 68; tag = "R6"; end
          else if (mbad) begin ex_cs = 4; vec = 64; tag = "R5"; end
          else if (obad) begin ex_cs = 5; vec = 60; tag = "R4"; end
          else if (rte)  begin ex_cs = 6; tag = "R10"; end
          else if (m == 0 && (flt || dstm || pc < 100)) tag = "R12";
          else tag = "R2";
          if (npend > 1) tag = {tag, " R9"};
          if (ex_cs >= 1 && ex_cs <= 5) begin
            tag = {tag, " R8"};
            ex_pc = vec; ex_epc = pc; ex_md = 0; ex_rd = 1; ex_rt = 0;
          end else if (ex_cs == 6) begin
            ex_pc = epc; ex_epc = pc; ex_md = 1; ex_rd = 1; ex_rt = 0;
          end else begin
            ex_pc = (pc + 4) % 256; ex_epc = epc; ex_rd = 0; ex_rt = 1;
            ex_md = dstm ? 1 : m;
          end
          irq_i = irq; trap_i = trp; dst_mode_i = dstm; rte_i = rte;
          mode_wdata_i = 1;
          opnd_vld_i = '1;
          for (int k = 0; k < NOPND; k++)
            opnd_addr_i[k*AW +: AW] = (flt && k == fport) ? 8'd99 : 8'd100;
          one_step();
          check($sformatf("%s mode=%0d pc=%0d combo=%0d", tag, m, pc, c),
                observed(), pack(ex_pc, ex_epc, ex_md, ex_cs, ex_rd, ex_rt));
        end
      end
    end

    // R4: invalid operand port with a low address is not checked
    reach(200, 1);
    opnd_vld_i = 3'b011;
    opnd_addr_i = {8'd5, 8'd100, 8'd100};
    one_step();
    check("R4 invalid port ignored", observed(), pack(204, 72, 1, 0, 0, 1));

    // R11: no step, other inputs active
    reach(200, 1);
    irq_i = 1; trap_i = 1; rte_i = 1; dst_mode_i = 1;
    opnd_vld_i = '1;
    tick();
    tick();
    check("R11 hold without step", observed(), pack(200, 72, 1, 6, 0, 0));
    clear_in();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule